// File: doc/BRIEF.md
# Subtractive GCD Processor

This block is a small custom processor that computes the greatest common divisor of two unsigned operands of a configurable width. It sits idle until the start input `go_i` is seen high, then loads both operands in one cycle. It then repeatedly subtracts the smaller working value from the larger until the two are equal, and publishes the result on `d_o` with a one-cycle `done` pulse.

The controller keeps only the states that do work: wait, load, compare, subtract-into-x and subtract-into-y. The equality test and the less-than choice are made together in the compare state, and each subtract state returns straight to compare. One subtractor serves both subtract states, with its inputs swapped by the state. An operand of zero ends the run at once, so the loop cannot hang. A request is accepted only when the block is idle.

Top module: `gcd_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters the idle state and clears `d_o` and `done` to 0.
- R2: While idle with `go_i` low, the block stays idle and `done` stays low.
- R3: The rising edge that samples `go_i` high in the idle state starts a run. The next edge loads both operands together. Each subtraction costs two cycles. `done` is therefore high during the cycle that follows edge 2+2n, counting from the start edge, where n is the number of subtractions.
- R4: In each iteration, if x < y then y becomes y − x, otherwise x becomes x − y. The loop stops when x equals y, and `d_o` then equals the greatest common divisor of the two operands.
- R5: Operands 42 and 8 give `d_o` = 2 after exactly 8 subtractions, so `done` is high after edge 18.
- R6: If both operands are zero, the result is 0. If only one operand is zero, the result is the other operand. In both cases no subtraction is made, and `done` follows edge 2.
- R7: `done` is high for exactly one cycle per result. `d_o` changes only in a cycle where `done` is high and otherwise holds its value.
- R8: Changes on `go_i`, `x_i` or `y_i` while a run is in progress do not affect the result or its timing.
- R9: If `go_i` is still high in the cycle where `done` is high, a new run starts at the next edge, with no extra idle cycle.
- R10: One shared subtractor produces both x − y and y − x. A subtract step writes only its target register and leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start request, sampled while idle |
| x_i | input | W | First operand |
| y_i | input | W | Second operand |
| d_o | output | W | Result, held until the next result |
| done | output | 1 | One-cycle pulse marking a new result on `d_o` |

## Verification
Two things can happen in the same cycle: a result is published, and a new start request is seen. This is provoked by holding `go_i` high through the end of a run while presenting fresh operands in the cycle where `done` rises. The bench checks three things: the first result is correct and is not disturbed by the request that was pending while the block was busy; the second run starts one edge later; and the second run's `done` falls exactly on the cycle the bench predicts from its own subtraction count. A separate scenario pulses `go_i` and changes the operands in the middle of a run. It then confirms that the result and the latency both match the operands that were originally loaded.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // Controller states: only the states that do work remain.
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LOAD = 3'd1,
    S_CMP  = 3'd2,
    S_SUBX = 3'd3,
    S_SUBY = 3'd4
  } gcd_state_e;

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic       finish,
  input  logic       x_lt_y,
  output logic       ld,
  output logic       sub_x,
  output logic       sub_y,
  output logic       wr_res
);

  gcd_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  state_d = go_i ? S_LOAD : S_IDLE;
      S_LOAD:  state_d = S_CMP;
      S_CMP: begin
        if (finish)      state_d = S_IDLE;
        else if (x_lt_y) state_d = S_SUBY;
        else             state_d = S_SUBX;
      end
      S_SUBX:  state_d = S_CMP;
      S_SUBY:  state_d = S_CMP;
      default: state_d = S_IDLE;
    endcase
  end

  // Named control events, brought out for the datapath and the assertions.
  assign ld     = (state_q == S_LOAD);
  assign sub_x  = (state_q == S_SUBX);
  assign sub_y  = (state_q == S_SUBY);
  assign wr_res = (state_q == S_CMP) && finish;

  // R2: idle holds while no request is seen
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && !go_i) |=> (state_q == S_IDLE));

  // R3: the load step always goes to compare
  a_r3_load_then_cmp: assert property (@(posedge clk) disable iff (rst)
    ld |=> (state_q == S_CMP));

  // R8: no new load can begin unless the previous cycle was idle
  a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> !ld);

  // R4: every subtract step returns straight to compare
  a_r4_sub_returns: assert property (@(posedge clk) disable iff (rst)
    (sub_x || sub_y) |=> (state_q == S_CMP));

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ld,
  input  logic         sub_x,
  input  logic         sub_y,
  input  logic         wr_res,
  output logic         finish,
  output logic         x_lt_y,
  output logic [W-1:0] d_o,
  output logic         done
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] x_q, y_q;
  logic [W-1:0] minu, subt, diff;
  logic         eq, any_zero;
  logic         armed;

  // Result choice: a zero operand yields the other; equal values yield x.
  function automatic logic [W-1:0] pick_result(input logic [W-1:0] a,
                                               input logic [W-1:0] b);
    if (b == ZERO) return a;
    if (a == ZERO) return b;
    return a;
  endfunction

  // The single shared subtractor; its operands are swapped by the step kind.
  function automatic logic [W-1:0] shared_sub(input logic [W-1:0] p,
                                              input logic [W-1:0] q);
    return p - q;
  endfunction

  assign eq       = (x_q == y_q);
  assign any_zero = (x_q == ZERO) || (y_q == ZERO);
  assign finish   = eq || any_zero;
  assign x_lt_y   = (x_q < y_q);

  assign minu = sub_y ? y_q : x_q;
  assign subt = sub_y ? x_q : y_q;
  assign diff = shared_sub(minu, subt);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= ZERO;
      y_q <= ZERO;
    end else if (ld) begin
      x_q <= x_i;
      y_q <= y_i;
    end else if (sub_x) begin
      x_q <= diff;
    end else if (sub_y) begin
      y_q <= diff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_o  <= ZERO;
      done <= 1'b0;
    end else begin
      done <= wr_res;
      if (wr_res) d_o <= pick_result(x_q, y_q);
    end
  end

  // Arms the history-based checks two edges after reset.
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7: done never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: d_o moves only together with done
  a_r7_result_held: assert property (@(posedge clk) disable iff (rst || !armed)
    (d_o != $past(d_o)) |-> done);

  // R4: a subtract step always removes the smaller value from the larger one
  a_r4_sub_x_order: assert property (@(posedge clk) disable iff (rst)
    sub_x |-> (y_q < x_q) && (y_q != ZERO));
  a_r4_sub_y_order: assert property (@(posedge clk) disable iff (rst)
    sub_y |-> (x_q < y_q) && (x_q != ZERO));

  // R10: a step writes only its target register, via the shared unit
  a_r10_x_step: assert property (@(posedge clk) disable iff (rst || !armed)
    sub_x |=> (x_q == $past(x_q) - $past(y_q)) && (y_q == $past(y_q)));
  a_r10_y_step: assert property (@(posedge clk) disable iff (rst || !armed)
    sub_y |=> (y_q == $past(y_q) - $past(x_q)) && (x_q == $past(x_q)));

  // R6: a zero operand always ends the loop
  a_r6_zero_ends: assert property (@(posedge clk) disable iff (rst)
    (any_zero && !ld && !sub_x && !sub_y) |-> finish);

  // R1: no two control events at once
  a_r1_ctrl_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld, sub_x, sub_y, wr_res}));

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] d_o,
  output logic         done
);

  logic ld, sub_x, sub_y, wr_res, finish, x_lt_y;

  gcd_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .go_i   (go_i),
    .finish (finish),
    .x_lt_y (x_lt_y),
    .ld     (ld),
    .sub_x  (sub_x),
    .sub_y  (sub_y),
    .wr_res (wr_res)
  );

  gcd_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .x_i    (x_i),
    .y_i    (y_i),
    .ld     (ld),
    .sub_x  (sub_x),
    .sub_y  (sub_y),
    .wr_res (wr_res),
    .finish (finish),
    .x_lt_y (x_lt_y),
    .d_o    (d_o),
    .done   (done)
  );

  // R2: a result can only appear after a run was started
  a_r2_done_needs_run: assert property (@(posedge clk) disable iff (rst)
    wr_res |-> !ld);

endmodule

// File: tb/gcd_engine_test.sv
module gcd_engine_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go_i = 1'b0;
  logic [W-1:0] x_i = '0;
  logic [W-1:0] y_i = '0;
  logic [W-1:0] d_o;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  gcd_engine #(.W(W)) uut (
    .clk(clk), .rst(rst), .go_i(go_i), .x_i(x_i), .y_i(y_i),
    .d_o(d_o), .done(done)
  );

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected result by Euclid's modulo form.
  function automatic int ref_gcd(input int a, input int b);
    int p = a, q = b, t;
    if (p == 0) return q;
    while (q != 0) begin t = p % q; p = q; q = t; end
    return p;
  endfunction

  // Subtraction count: sum of Euclid quotients, minus one.
  function automatic int ref_steps(input int a, input int b);
    int p = a, q = b, n = 0, t;
    if (p == 0 || q == 0) return 0;
    if (p < q) begin t = p; p = q; q = t; end
    while (q != 0) begin n += p / q; t = p % q; p = q; q = t; end
    return n - 1;
  endfunction

  // Wait on negedges for done; returns negedges elapsed (or -1 on timeout).
  task automatic wait_done(output int m);
    m = -1;
    for (int k = 1; k <= 2000; k++) begin
      @(negedge clk);
      if (done) begin m = k; return; end
    end
  endtask

  // R3/R4/R7: one run with a pulse on go_i, checks latency, result, hold.
  task automatic run_case(input int a, input int b, input string req);
    int m;
    logic [W-1:0] held;
    @(negedge clk);
    x_i = W'(a); y_i = W'(b); go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    // the start edge has passed; the first negedge of wait_done is edge 1
    wait_done(m);
    check({req, " latency"}, m, 2 + 2 * ref_steps(a, b));
    check({req, " result"}, int'(d_o), ref_gcd(a, b));
    held = d_o;
    @(negedge clk);
    check("R7 done width", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R7 d_o held", int'(d_o), int'(held));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 d_o after reset", int'(d_o), 0);
    rst = 1'b0;
  endtask

  task automatic t_idle;
    int seen = 0;
    x_i = 8'd9; y_i = 8'd3;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R2 no done while idle", seen, 0);
  endtask

  // R8: go_i and operands disturbed mid-run.
  task automatic t_busy_ignore;
    int m;
    @(negedge clk);
    x_i = 8'd200; y_i = 8'd75; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    repeat (3) @(negedge clk);
    x_i = 8'd7; y_i = 8'd1; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      go_i = ~go_i;
    end
    go_i = 1'b0;
    wait_done(m);
    check("R8 latency unchanged", m + 6, 2 + 2 * ref_steps(200, 75));
    check("R8 result unchanged", int'(d_o), ref_gcd(200, 75));
    repeat (4) @(negedge clk);
    check("R8 no extra run", int'(done), 0);
  endtask

  // R9: go_i held through done; next run starts with no gap.
  task automatic t_back_to_back;
    int m;
    @(negedge clk);
    x_i = 8'd12; y_i = 8'd18; go_i = 1'b1;
    @(negedge clk);
    wait_done(m);
    check("R9 first latency", m, 2 + 2 * ref_steps(12, 18));
    check("R9 first result", int'(d_o), 6);
    x_i = 8'd35; y_i = 8'd21;
    // start edge is the next edge; done follows edge 2+2n after it
    wait_done(m);
    check("R9 second latency", m, 1 + 2 + 2 * ref_steps(35, 21));
    check("R9 second result", int'(d_o), 7);
    go_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 stops when go low", int'(done), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    run_case(42, 8, "R5");
    check("R5 step count", ref_steps(42, 8), 8);
    run_case(8, 42, "R4 swapped");
    run_case(17, 17, "R4 equal");
    run_case(255, 1, "R4 long");
    run_case(144, 89, "R4 fibonacci");
    run_case(0, 0, "R6 both zero");
    run_case(0, 37, "R6 x zero");
    run_case(91, 0, "R6 y zero");
    run_case(60, 48, "R10 both paths");
    t_busy_ignore();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule